// File: doc/BRIEF.md
# Programmable-Priority Interrupt Controller

This block gathers a set of interrupt request lines, each identified by its vector number, and presents one winning request at a time to a processor core. The core receives the vector number, the 2-bit priority level and a flag saying whether the vector is one of two registered fast vectors. Software sets a 2-bit priority code for every source through a small register bus. The same bus gives read access to the raw pending status of all sources and holds the two fast-vector match registers. It also holds the sensing mode for two active-low external request pins.

Arbitration picks the highest priority level first. Among the requests at that level, the one with the smallest vector number wins. Most sources can be placed on levels 0 to 2. A class of sources selected by a parameter mask uses levels 1 to 3 instead. The external pins pass through a two-flop synchronizer. Each pin is then either level-sensed, or edge-latched and held until the core acknowledges it.

Top module: `pic_top`

## Requirements
- R1: After reset every priority field, both fast-match registers and the control bits read 0. Both pins are level-sensed, and no request is presented (irq_req_o, irq_vec_o, irq_lvl_o and irq_fast_o are all 0).
- R2: The priority code of vector v sits in register word v/8, bits [2*(v%8)+1 : 2*(v%8)]. The fields of vectors below FIRST_VEC always read 00 and ignore writes.
- R3: Priority code 00 disables a source. A disabled source is never presented, even while its request is asserted.
- R4: For a source outside the HIGH_CLASS mask, codes 01, 10 and 11 present levels 0, 1 and 2 on irq_lvl_o.
- R5: For a source inside the HIGH_CLASS mask, codes 01, 10 and 11 present levels 1, 2 and 3.
- R6: A pending, enabled request on a higher level wins over any request on a lower level, whatever the vector numbers.
- R7: Among the pending, enabled requests on the winning level, the lowest vector number is presented.
- R8: Pending word k sits at address PW+3+k, where PW = ceil(NUM_VEC/8). Bit b of word k is 1 while the request of vector 16k+b is asserted, whatever its priority code. Bit positions of vectors below FIRST_VEC or at NUM_VEC and above read 1, and writes to these words change nothing.
- R9: The fast-match registers sit at addresses PW and PW+1, with the vector in the low bits. irq_fast_o is 1 when the presented vector equals either register. Software must give such a vector level 2.
- R10: The control word at address PW+2 holds the pin sensing modes in bits 1:0 (pin 0 in bit 0, pin 1 in bit 1; 1 selects falling-edge, 0 selects low-level). Bit 15 reads the current irq_req_o and bits 14:13 read the current irq_lvl_o.
- R11: A level-sensed pin drives its vector (EXT_A for pin 0, EXT_B for pin 1) as a request while it is low, and withdraws it once it is high.
- R12: An edge-sensed pin latches a falling edge. The request stays set after the pin returns high and clears only when ack_i is asserted with ack_vec_i equal to that pin's vector.
- R13: While lp_mode_i is 1, both pins are level-sensed whatever their control bits.
- R14: A change on irq_i appears on the outputs after two rising clock edges. Pending capture is one edge and the registered arbitration result is the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq_i | input | NUM_VEC | Request line per vector number, active high. At EXT_A and EXT_B it is ORed with the pin request |
| ext_pin_n_i | input | 2 | External request pins, active low, asynchronous |
| lp_mode_i | input | 1 | Low-power indication; forces level sensing on the pins |
| ack_i | input | 1 | Core acknowledge strobe |
| ack_vec_i | input | VW | Vector being acknowledged |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | AW | Register word address |
| bus_wdata_i | input | 16 | Register write data |
| bus_rdata_o | output | 16 | Register read data (combinational) |
| irq_req_o | output | 1 | A request is being presented |
| irq_vec_o | output | VW | Presented vector number |
| irq_lvl_o | output | 2 | Presented priority level |
| irq_fast_o | output | 1 | Presented vector matches a fast-match register |

## Verification
The bench builds the block with NUM_VEC = 40, FIRST_VEC = 2, HIGH_CLASS covering vectors 2 to 5, and the pins on vectors 8 and 9. This gives five full priority words and three pending words. The last pending word holds eight unimplemented tail positions, which puts the read-as-one padding within reach of a single read. With these values, level-3 winners, the shared level 1 of both source classes and the paths of both pins all occur in a short run.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int FIELD_W = 2;
  localparam int WORD_W  = 16;
  localparam int FIELDS_PER_WORD = WORD_W / FIELD_W;
  localparam int NUM_LVL = 4;

  // Map a non-zero priority code onto the level presented to the core.
  function automatic logic [1:0] code_to_level(input logic [1:0] code, input logic high_class);
    return high_class ? code : (code - 2'd1);
  endfunction
endpackage

// File: rtl/pic_pin_cond.sv
module pic_pin_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n_i,
  input  logic edge_sel_i,
  input  logic lp_i,
  input  logic clr_i,
  output logic req_o
);
  logic s1_q, s2_q, prev_q, ped_q;
  logic ped_d, edge_eff, fall;

  assign edge_eff = edge_sel_i & ~lp_i;
  assign fall     = prev_q & ~s2_q;

  always_comb begin
    ped_d = ped_q;
    if (clr_i)            ped_d = 1'b0;
    if (edge_eff && fall) ped_d = 1'b1;
    if (!edge_eff)        ped_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
      ped_q  <= 1'b0;
    end else begin
      s1_q   <= pin_n_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      ped_q  <= ped_d;
    end
  end

  assign req_o = edge_eff ? ped_q : ~s2_q;

  // R12: a latched edge survives until an acknowledge
  a_r12_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ped_q && !clr_i && edge_eff) |=> ped_q);
endmodule

// File: rtl/pic_regfile.sv
module pic_regfile #(
  parameter int NUM_VEC   = 82,
  parameter int FIRST_VEC = 2,
  parameter int VW        = 7,
  parameter int AW        = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_we_i,
  input  logic [AW-1:0]          bus_addr_i,
  input  logic [15:0]            bus_wdata_i,
  output logic [15:0]            bus_rdata_o,
  input  logic [NUM_VEC-1:0]     pend_i,
  input  logic                   stat_req_i,
  input  logic [1:0]             stat_lvl_i,
  output logic [2*NUM_VEC-1:0]   prio_o,
  output logic [VW-1:0]          fast0_o,
  output logic [VW-1:0]          fast1_o,
  output logic [1:0]             edge_sel_o
);
  import pic_pkg::*;

  localparam int PW      = (NUM_VEC + FIELDS_PER_WORD - 1) / FIELDS_PER_WORD;
  localparam int NPW     = (NUM_VEC + WORD_W - 1) / WORD_W;
  localparam int A_FAST0 = PW;
  localparam int A_FAST1 = PW + 1;
  localparam int A_CTRL  = PW + 2;
  localparam int A_PEND  = PW + 3;

  // Priority fields: storage only for programmable vectors
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_fld
    if (v >= FIRST_VEC) begin : g_impl
      logic [1:0] fld_q;
      logic [1:0] fld_d;
      logic       fld_en;
      assign fld_en = bus_we_i && (bus_addr_i == AW'(v / FIELDS_PER_WORD));
      assign fld_d  = bus_wdata_i[FIELD_W*(v % FIELDS_PER_WORD) +: FIELD_W];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      fld_q <= 2'b00;
        else if (fld_en) fld_q <= fld_d;
      end
      assign prio_o[FIELD_W*v +: FIELD_W] = fld_q;
    end else begin : g_void
      assign prio_o[FIELD_W*v +: FIELD_W] = 2'b00;
    end
  end

  // Fast-match and control registers
  logic [VW-1:0] fast0_q, fast1_q, fast0_d, fast1_d;
  logic [1:0]    edge_q, edge_d;
  logic          we_f0, we_f1, we_ctl;

  assign we_f0  = bus_we_i && (bus_addr_i == AW'(A_FAST0));
  assign we_f1  = bus_we_i && (bus_addr_i == AW'(A_FAST1));
  assign we_ctl = bus_we_i && (bus_addr_i == AW'(A_CTRL));

  always_comb begin
    fast0_d = fast0_q;
    fast1_d = fast1_q;
    edge_d  = edge_q;
    if (we_f0)  fast0_d = bus_wdata_i[VW-1:0];
    if (we_f1)  fast1_d = bus_wdata_i[VW-1:0];
    if (we_ctl) edge_d  = bus_wdata_i[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast0_q <= '0;
      fast1_q <= '0;
      edge_q  <= '0;
    end else begin
      fast0_q <= fast0_d;
      fast1_q <= fast1_d;
      edge_q  <= edge_d;
    end
  end

  assign fast0_o    = fast0_q;
  assign fast1_o    = fast1_q;
  assign edge_sel_o = edge_q;

  // Read path
  logic [PW*WORD_W-1:0]  prio_pad;
  logic [NPW*WORD_W-1:0] pend_pad;

  always_comb begin
    prio_pad = '0;
    prio_pad[2*NUM_VEC-1:0] = prio_o;
    pend_pad = '1;
    pend_pad[NUM_VEC-1:0] = pend_i;
    for (int i = 0; i < FIRST_VEC; i++) pend_pad[i] = 1'b1;
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int w = 0; w < PW; w++)
      if (bus_addr_i == AW'(w)) bus_rdata_o = prio_pad[WORD_W*w +: WORD_W];
    for (int w = 0; w < NPW; w++)
      if (bus_addr_i == AW'(A_PEND + w)) bus_rdata_o = pend_pad[WORD_W*w +: WORD_W];
    if (bus_addr_i == AW'(A_FAST0)) bus_rdata_o = 16'(fast0_q);
    if (bus_addr_i == AW'(A_FAST1)) bus_rdata_o = 16'(fast1_q);
    if (bus_addr_i == AW'(A_CTRL))  bus_rdata_o = {stat_req_i, stat_lvl_i, 11'b0, edge_q};
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int                   NUM_VEC    = 82,
  parameter int                   VW         = 7,
  parameter logic [NUM_VEC-1:0]   HIGH_CLASS = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_VEC-1:0]    pend_i,
  input  logic [2*NUM_VEC-1:0]  prio_i,
  input  logic [VW-1:0]         fast0_i,
  input  logic [VW-1:0]         fast1_i,
  output logic                  req_o,
  output logic [VW-1:0]         vec_o,
  output logic [1:0]            lvl_o,
  output logic                  fast_o
);
  import pic_pkg::*;

  logic [NUM_LVL-1:0][NUM_VEC-1:0] cand;
  logic [NUM_LVL-1:0][VW-1:0]      first_v;
  logic [NUM_LVL-1:0]              lvl_any;

  // Per source: sort the request into the bucket of its level
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_src
    logic [1:0] code;
    logic [1:0] lvl;
    assign code = prio_i[2*v +: 2];
    assign lvl  = code_to_level(code, HIGH_CLASS[v]);
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_bkt
      assign cand[l][v] = pend_i[v] && (code != 2'b00) && (lvl == 2'(l));
    end
  end

  // Per level: lowest set vector
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic [VW-1:0] fv;
    always_comb begin
      fv = '0;
      for (int v = NUM_VEC - 1; v >= 0; v--)
        if (cand[l][v]) fv = VW'(v);
    end
    assign first_v[l] = fv;
    assign lvl_any[l] = |cand[l];
  end

  logic          win_ok, win_fast;
  logic [1:0]    win_lvl;
  logic [VW-1:0] win_vec;

  always_comb begin
    win_ok  = 1'b0;
    win_lvl = 2'd0;
    win_vec = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (lvl_any[l]) begin
        win_ok  = 1'b1;
        win_lvl = 2'(l);
        win_vec = first_v[l];
      end
    end
    win_fast = win_ok && ((win_vec == fast0_i) || (win_vec == fast1_i));
  end

  // Registered presentation to the core
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_o  <= 1'b0;
      vec_o  <= '0;
      lvl_o  <= 2'd0;
      fast_o <= 1'b0;
    end else begin
      req_o  <= win_ok;
      vec_o  <= win_vec;
      lvl_o  <= win_lvl;
      fast_o <= win_fast;
    end
  end

  // R3: a winner is pending and has a non-zero code
  a_r3_winner_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    win_ok |-> (pend_i[win_vec] && (prio_i[2*win_vec +: 2] != 2'b00)));
  // R6: nothing is requested above the winning level
  a_r6_level_first: assert property (@(posedge clk) disable iff (!rst_n)
    win_ok |-> ((lvl_any >> win_lvl) == 4'b0001));
  // R7: nothing with a smaller vector on the winning level
  a_r7_lowest_vector: assert property (@(posedge clk) disable iff (!rst_n)
    win_ok |-> ((cand[win_lvl] & ~({NUM_VEC{1'b1}} << win_vec)) == '0));
  // R9: fast flag only with a presented request
  a_r9_fast_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    fast_o |-> req_o);
  // R1: idle presentation is all zero
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !req_o |-> (vec_o == '0 && lvl_o == 2'd0 && !fast_o));
endmodule

// File: rtl/pic_top.sv
module pic_top #(
  parameter int                 NUM_VEC    = 82,
  parameter int                 FIRST_VEC  = 2,
  parameter logic [NUM_VEC-1:0] HIGH_CLASS = NUM_VEC'(60),
  parameter int                 EXT_A      = 18,
  parameter int                 EXT_B      = 19,
  localparam int                VW         = $clog2(NUM_VEC),
  localparam int                PW         = (NUM_VEC + 7) / 8,
  localparam int                NPW        = (NUM_VEC + 15) / 16,
  localparam int                AW         = $clog2(PW + 3 + NPW)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] irq_i,
  input  logic [1:0]         ext_pin_n_i,
  input  logic               lp_mode_i,
  input  logic               ack_i,
  input  logic [VW-1:0]      ack_vec_i,
  input  logic               bus_we_i,
  input  logic [AW-1:0]      bus_addr_i,
  input  logic [15:0]        bus_wdata_i,
  output logic [15:0]        bus_rdata_o,
  output logic               irq_req_o,
  output logic [VW-1:0]      irq_vec_o,
  output logic [1:0]         irq_lvl_o,
  output logic               irq_fast_o
);
  logic [2*NUM_VEC-1:0] prio;
  logic [VW-1:0]        fast0, fast1;
  logic [1:0]           edge_sel;
  logic [1:0]           ext_req;
  logic [1:0]           ext_clr;
  logic [NUM_VEC-1:0]   pend_d, pend_q;

  assign ext_clr[0] = ack_i && (ack_vec_i == VW'(EXT_A));
  assign ext_clr[1] = ack_i && (ack_vec_i == VW'(EXT_B));

  for (genvar p = 0; p < 2; p++) begin : g_pin
    pic_pin_cond i_cond (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_n_i    (ext_pin_n_i[p]),
      .edge_sel_i (edge_sel[p]),
      .lp_i       (lp_mode_i),
      .clr_i      (ext_clr[p]),
      .req_o      (ext_req[p])
    );
  end

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_pend
    if (v == EXT_A) begin : g_a
      assign pend_d[v] = irq_i[v] | ext_req[0];
    end else if (v == EXT_B) begin : g_b
      assign pend_d[v] = irq_i[v] | ext_req[1];
    end else begin : g_p
      assign pend_d[v] = irq_i[v];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  pic_regfile #(
    .NUM_VEC   (NUM_VEC),
    .FIRST_VEC (FIRST_VEC),
    .VW        (VW),
    .AW        (AW)
  ) i_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .pend_i      (pend_q),
    .stat_req_i  (irq_req_o),
    .stat_lvl_i  (irq_lvl_o),
    .prio_o      (prio),
    .fast0_o     (fast0),
    .fast1_o     (fast1),
    .edge_sel_o  (edge_sel)
  );

  pic_arbiter #(
    .NUM_VEC    (NUM_VEC),
    .VW         (VW),
    .HIGH_CLASS (HIGH_CLASS)
  ) i_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend_i  (pend_q),
    .prio_i  (prio),
    .fast0_i (fast0),
    .fast1_i (fast1),
    .req_o   (irq_req_o),
    .vec_o   (irq_vec_o),
    .lvl_o   (irq_lvl_o),
    .fast_o  (irq_fast_o)
  );
endmodule

// File: tb/test_pic_top.sv
module test_pic_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV   = 40;
  localparam int VWB  = 6;
  localparam int AWB  = 4;
  localparam int A_F0 = 5, A_F1 = 6, A_CTL = 7, A_PND = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [NV-1:0] irq;
  logic [1:0] pin_n;
  logic lp, ack;
  logic [VWB-1:0] ack_vec;
  logic we;
  logic [AWB-1:0] addr;
  logic [15:0] wdata, rdata;
  logic req, fast;
  logic [VWB-1:0] vec;
  logic [1:0] lvl;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_top #(
    .NUM_VEC (NV), .FIRST_VEC (2), .HIGH_CLASS (40'h3C), .EXT_A (8), .EXT_B (9)
  ) i_pic_top (
    .clk (clk), .rst_n (rst_n), .irq_i (irq), .ext_pin_n_i (pin_n),
    .lp_mode_i (lp), .ack_i (ack), .ack_vec_i (ack_vec),
    .bus_we_i (we), .bus_addr_i (addr), .bus_wdata_i (wdata), .bus_rdata_o (rdata),
    .irq_req_o (req), .irq_vec_o (vec), .irq_lvl_o (lvl), .irq_fast_o (fast)
  );

  // {irq lines, expected req, vec, lvl, fast}
  localparam logic [49:0] TBL [14] = '{
    {40'h0000000000, 1'b0, 6'd0,  2'd0, 1'b0},  // R1 idle
    {40'h0000100000, 1'b1, 6'd20, 2'd0, 1'b0},  // R4 code 01 -> level 0
    {40'h0000200000, 1'b0, 6'd0,  2'd0, 1'b0},  // R3 disabled alone
    {40'h0000300000, 1'b1, 6'd20, 2'd0, 1'b0},  // R3 disabled beside enabled
    {40'h0000100800, 1'b1, 6'd11, 2'd1, 1'b0},  // R6 level 1 over level 0
    {40'h0000001400, 1'b1, 6'd10, 2'd2, 1'b0},  // R7 tie on level 2
    {40'h0000001000, 1'b1, 6'd12, 2'd2, 1'b1},  // R9 fast slot 0
    {40'h8040000000, 1'b1, 6'd39, 2'd2, 1'b1},  // R6 R9 higher vector, higher level, slot 1
    {40'h8000000004, 1'b1, 6'd2,  2'd3, 1'b0},  // R5 level 3
    {40'h0040000008, 1'b1, 6'd3,  2'd1, 1'b0},  // R5 R7 level 1 shared by both classes
    {40'h0000000010, 1'b0, 6'd0,  2'd0, 1'b0},  // R3 high-class disabled
    {40'h0000000003, 1'b0, 6'd0,  2'd0, 1'b0},  // R2 unprogrammable vectors
    {40'h0000100808, 1'b1, 6'd3,  2'd1, 1'b0},  // R7 three sources
    {40'hFFFFFFFFFF, 1'b1, 6'd2,  2'd3, 1'b0}   // R6 everything asserted
  };

  function automatic logic [9:0] obs();
    return {req, vec, lvl, fast};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = AWB'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk);
    addr = AWB'(a);
    #1 d = rdata;
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    rst_n = 1'b0; irq = '0; pin_n = 2'b11; lp = 1'b0; ack = 1'b0; ack_vec = '0;
    we = 1'b0; addr = '0; wdata = '0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);

    // R1 reset state
    check("R1 outputs after reset", 32'(obs()), 32'h0);
    rd(1, d);     check("R1 priority word", 32'(d), 32'h0);
    rd(A_CTL, d); check("R1 control word", 32'(d), 32'h0);
    rd(A_F0, d);  check("R1 fast match", 32'(d), 32'h0);

    // Configuration
    wr(0, 16'h007F);
    wr(1, 16'h03BA);
    wr(2, 16'h0100);
    wr(3, 16'h2000);
    wr(4, 16'hC000);
    wr(A_F0, 16'd12);
    wr(A_F1, 16'd39);
    rd(0, d);    check("R2 low fields ignore writes", 32'(d), 32'h0070);
    rd(1, d);    check("R2 word 1 readback", 32'(d), 32'h03BA);
    rd(A_F1, d); check("R9 fast slot 1 readback", 32'(d), 32'd39);

    // Table walk
    foreach (TBL[i]) begin
      @(negedge clk);
      irq = TBL[i][49:10];
      wait_clk(2);
      check($sformatf("R3 R4 R5 R6 R7 R9 table row %0d", i), 32'(obs()), 32'(TBL[i][9:0]));
    end

    // R14 latency
    irq = '0; wait_clk(3);
    irq = 40'h0000100000;
    @(negedge clk);
    check("R14 unchanged after one edge", 32'(obs()), 32'h0);
    @(negedge clk);
    check("R14 presented after two edges", 32'(obs()), 32'({1'b1, 6'd20, 2'd0, 1'b0}));

    // R8 pending words
    irq = 40'h0000200020;
    wait_clk(2);
    rd(A_PND, d);     check("R8 pending word 0", 32'(d), 32'h0023);
    rd(A_PND + 1, d); check("R8 pending word 1", 32'(d), 32'h0020);
    rd(A_PND + 2, d); check("R8 pending tail reads one", 32'(d), 32'hFF00);
    wr(A_PND, 16'hFFFF);
    rd(A_PND, d);     check("R8 pending write ignored", 32'(d), 32'h0023);

    // R10 status fields
    irq = 40'h0000000800;
    wait_clk(3);
    rd(A_CTL, d); check("R10 status with level 1 request", 32'(d), 32'hA000);
    wr(A_CTL, 16'h0001);
    rd(A_CTL, d); check("R10 edge mode bit readback", 32'(d), 32'hA001);
    irq = '0;
    wait_clk(3);

    // R11 level-sensed pin 1 (vector 9, level 1)
    pin_n[1] = 1'b0;
    wait_clk(5);
    check("R11 low pin presents", 32'(obs()), 32'({1'b1, 6'd9, 2'd1, 1'b0}));
    pin_n[1] = 1'b1;
    wait_clk(5);
    check("R11 released pin withdraws", 32'(obs()), 32'h0);

    // R12 edge-sensed pin 0 (vector 8, level 1)
    pin_n[0] = 1'b0;
    wait_clk(3);
    pin_n[0] = 1'b1;
    wait_clk(6);
    check("R12 edge held after release", 32'(obs()), 32'({1'b1, 6'd8, 2'd1, 1'b0}));
    ack = 1'b1; ack_vec = 6'd9;
    @(negedge clk);
    ack = 1'b0;
    wait_clk(4);
    check("R12 other-vector ack keeps request", 32'(obs()), 32'({1'b1, 6'd8, 2'd1, 1'b0}));
    ack = 1'b1; ack_vec = 6'd8;
    @(negedge clk);
    ack = 1'b0;
    wait_clk(4);
    check("R12 ack clears request", 32'(obs()), 32'h0);

    // R13 low-power forces level sensing
    lp = 1'b1;
    pin_n[0] = 1'b0;
    wait_clk(3);
    pin_n[0] = 1'b1;
    wait_clk(6);
    check("R13 pulse not latched in low power", 32'(obs()), 32'h0);
    pin_n[0] = 1'b0;
    wait_clk(5);
    check("R13 low level presents in low power", 32'(obs()), 32'({1'b1, 6'd8, 2'd1, 1'b0}));
    pin_n[0] = 1'b1;
    lp = 1'b0;
    wait_clk(5);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule